// File: doc/BRIEF.md
# Multi-Channel Thermal Alert Controller

This block sits behind a small register port and watches a stream of signed die-temperature samples delivered by an external sensor front end as a valid strobe with a 9-bit value. Each accepted sample is kept for readback and, when temperature monitoring is selected, compared against three independently programmable over-temperature thresholds. A channel whose threshold is reached sets a sticky alert status bit. A single interrupt line reports any alert whose interrupt enable is set.

Software starts and stops monitoring with a run bit. After a start, samples are ignored for a settle interval counted in clock cycles. After a stop, a restart is refused until a stop interval has elapsed. Both intervals are visible as read-only flags. A repeat setting chooses between endless sampling and a single measurement per start.

Register map (byte offsets): 0x00 control, 0x04 mode, 0x08 repeat, 0x10/0x14/0x18 thresholds for channels 0/1/2, 0x20 interrupt control, 0x24 temperature. Unlisted offsets read zero and ignore writes.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The threshold register of channel n sits at 0x10+4n and holds an 8-bit unsigned threshold in bits 23:16 and a channel enable in bit 0. It reads back exactly as written, and all other bits read zero.
- R3: A channel's status bit sets when a sample is accepted in temperature mode, the channel is enabled, and the signed sample is greater than or equal to the zero-extended threshold. Negative samples never reach a threshold.
- R4: In the interrupt control register (0x20), channel n has enable at bit 4n, status at bit 4n+1 (read-only) and clear at bit 4n+2 (write 1, reads 0). Status stays set until it is cleared, and all other bits read zero.
- R5: If a clear and a new alert for the same channel occur in the same cycle, the status bit ends up set.
- R6: `irq_o` is high exactly when some channel has both its status and its interrupt enable set.
- R7: The temperature register (0x24) returns the last accepted sample as 9-bit two's complement in bits 8:0.
- R8: Control bit 0 is the run bit. While it is 0, no sample is accepted: the temperature and status are unchanged.
- R9: After run goes from 0 to 1, samples are ignored for SETTLE_CYC cycles. Control bit 8 reads 1 during that interval.
- R10: After run goes from 1 to 0, control bit 9 reads 1 for STOP_CYC cycles, and a write of run=1 during that interval is ignored.
- R11: The mode register (0x04, bits 3:0) enables comparison only at value 0x5. In other modes samples are still captured but set no status.
- R12: The repeat register (0x08) stores an endless bit at bit 24 and a period code at bits 3:0. With endless at 0, only the first accepted sample after each start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| smp_valid | input | 1 | Sensor sample strobe |
| smp_value | input | 9 | Sensor sample, signed whole degrees |
| irq_o | output | 1 | Combined alert interrupt |

## Verification
The bench builds the block with SETTLE_CYC=20 and STOP_CYC=30 instead of the microsecond-scale defaults. This lets it cross both the settle and stop windows several times: it checks that samples are rejected inside the settle window, that a restart is refused inside the stop window, and that single-shot mode re-arms across a full stop/start cycle. Threshold boundaries are probed one degree below and exactly at a threshold, with a zero threshold against samples of -1 and 0. A clear is also driven in the same cycle as a new alert.

// File: rtl/tac_pkg.sv
package tac_pkg;
    localparam int CH_N    = 3;
    localparam int TEMP_W  = 9;
    localparam int THR_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int MODE_W  = 4;
    localparam int PER_W   = 4;
    localparam int CH_STRIDE = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MODE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_REPEAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_THR0   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_INTC   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_TEMP   = 8'h24;

    localparam logic [MODE_W-1:0] MODE_TEMP = 4'h5;

    localparam int BIT_SETTLE  = 8;
    localparam int BIT_STOP    = 9;
    localparam int BIT_ENDLESS = 24;
    localparam int THR_LSB     = 16;

    typedef struct packed {
        logic                           run;
        logic [MODE_W-1:0]              mode;
        logic                           endless;
        logic [PER_W-1:0]               period;
        logic [CH_N-1:0][THR_W-1:0]     thr;
        logic [CH_N-1:0]                thr_en;
        logic [CH_N-1:0]                ie;
        logic [TEMP_W-1:0]              temp;
        logic                           shot_done;
    } tac_regs_t;
endpackage

// File: rtl/tac_phase_timer.sv
module tac_phase_timer #(
    parameter int SETTLE_CYC = 175000,
    parameter int STOP_CYC   = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic settle_busy,
    output logic stop_busy
);
    localparam int MAX_CYC = (SETTLE_CYC > STOP_CYC) ? SETTLE_CYC : STOP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             phase_d, phase_q;   // 0: settling, 1: stopping
    logic             prev_d, prev_q;

    always_comb begin
        cnt_d   = cnt_q;
        phase_d = phase_q;
        prev_d  = run;
        if (run && !prev_q) begin
            cnt_d   = CNT_W'(SETTLE_CYC);
            phase_d = 1'b0;
        end else if (!run && prev_q) begin
            cnt_d   = CNT_W'(STOP_CYC);
            phase_d = 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
            prev_q  <= prev_d;
        end
    end

    assign settle_busy = (run && !prev_q) || ((cnt_q != '0) && !phase_q);
    assign stop_busy   = (!run && prev_q) || ((cnt_q != '0) && phase_q);
endmodule

// File: rtl/tac_channel.sv
module tac_channel
    import tac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              thr_en,
    input  logic [THR_W-1:0]  thr,
    input  logic [TEMP_W-1:0] sample,
    input  logic              clr,
    output logic              status
);
    logic signed [TEMP_W:0] s_ext;
    logic signed [TEMP_W:0] t_ext;
    logic                   hit;
    logic                   st_d, st_q;

    always_comb begin
        s_ext = {sample[TEMP_W-1], sample};
        t_ext = {{(TEMP_W + 1 - THR_W){1'b0}}, thr};
        hit   = go && thr_en && (s_ext >= t_ext);
        st_d  = st_q;
        if (clr) st_d = 1'b0;
        if (hit) st_d = 1'b1;     // new alert wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= st_d;
    end

    assign status = st_q;
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
    import tac_pkg::*;
#(
    parameter int SETTLE_CYC = 175000,
    parameter int STOP_CYC   = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] smp_value,
    output logic              irq_o
);
    tac_regs_t         regs_d, regs_q;
    logic [CH_N-1:0]   clr_ch;
    logic [CH_N-1:0]   status;
    logic              accept;
    logic              cmp_go;
    logic              settle_busy;
    logic              stop_busy;
    logic [TEMP_W-1:0] temp_view;
    logic              run_view;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    tac_phase_timer #(
        .SETTLE_CYC(SETTLE_CYC),
        .STOP_CYC  (STOP_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (regs_q.run),
        .settle_busy(settle_busy),
        .stop_busy  (stop_busy)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        tac_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (cmp_go),
            .thr_en(regs_q.thr_en[c]),
            .thr   (regs_q.thr[c]),
            .sample(smp_value),
            .clr   (clr_ch[c]),
            .status(status[c])
        );
    end

    // next-state logic
    always_comb begin
        regs_d = regs_q;
        clr_ch = '0;
        accept = regs_q.run && !settle_busy && smp_valid &&
                 (regs_q.endless || !regs_q.shot_done);
        cmp_go = accept && (regs_q.mode == MODE_TEMP);

        if (reg_we && reg_addr == OFF_CTRL) begin
            if (!(reg_wdata[0] && stop_busy)) begin
                regs_d.run = reg_wdata[0];
                if (reg_wdata[0] && !regs_q.run) regs_d.shot_done = 1'b0;
            end
        end
        if (reg_we && reg_addr == OFF_MODE)
            regs_d.mode = reg_wdata[MODE_W-1:0];
        if (reg_we && reg_addr == OFF_REPEAT) begin
            regs_d.endless = reg_wdata[BIT_ENDLESS];
            regs_d.period  = reg_wdata[PER_W-1:0];
        end
        for (int c = 0; c < CH_N; c++) begin
            if (reg_we && reg_addr == OFF_THR0 + ADDR_W'(CH_STRIDE * c)) begin
                regs_d.thr[c]    = reg_wdata[THR_LSB +: THR_W];
                regs_d.thr_en[c] = reg_wdata[0];
            end
            if (reg_we && reg_addr == OFF_INTC) begin
                regs_d.ie[c] = reg_wdata[4*c];
                clr_ch[c]    = reg_wdata[4*c + 2];
            end
        end

        if (accept) begin
            regs_d.temp = smp_value;
            if (!regs_q.endless) regs_d.shot_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_CTRL) begin
            reg_rdata[0]          = regs_q.run;
            reg_rdata[BIT_SETTLE] = settle_busy;
            reg_rdata[BIT_STOP]   = stop_busy;
        end
        if (reg_addr == OFF_MODE)
            reg_rdata[MODE_W-1:0] = regs_q.mode;
        if (reg_addr == OFF_REPEAT) begin
            reg_rdata[BIT_ENDLESS] = regs_q.endless;
            reg_rdata[PER_W-1:0]   = regs_q.period;
        end
        for (int c = 0; c < CH_N; c++) begin
            if (reg_addr == OFF_THR0 + ADDR_W'(CH_STRIDE * c)) begin
                reg_rdata[THR_LSB +: THR_W] = regs_q.thr[c];
                reg_rdata[0]                = regs_q.thr_en[c];
            end
            if (reg_addr == OFF_INTC) begin
                reg_rdata[4*c]     = regs_q.ie[c];
                reg_rdata[4*c + 1] = status[c];
            end
        end
        if (reg_addr == OFF_TEMP)
            reg_rdata[TEMP_W-1:0] = regs_q.temp;
    end

    assign irq_o     = |(status & regs_q.ie);
    assign temp_view = regs_q.temp;
    assign run_view  = regs_q.run;
endmodule

// File: rtl/tac_checker.sv
module tac_checker
    import tac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_o,
    input logic [CH_N-1:0]   status,
    input logic [TEMP_W-1:0] temp,
    input logic              run,
    input logic              settle_busy,
    input logic              stop_busy
);
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    // R6: interrupt only when some alert is latched
    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|status));

    // R4: latched status persists unless its clear bit is written
    for (genvar c = 0; c < CH_N; c++) begin : g_sticky
        p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (status[c] && !(reg_we && reg_addr == OFF_INTC && reg_wdata[4*c + 2]))
            |=> status[c]);
    end

    // R8: no sample taken while stopped
    p_norun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(temp));

    // R9: settle window opens on start and blocks samples
    p_settle_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> settle_busy);
    p_settle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        settle_busy |=> $stable(temp));

    // R10: no restart inside the stop window
    p_restart_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_busy |=> !run);
endmodule

bind thermal_alert_ctrl tac_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_o      (irq_o),
    .status     (status),
    .temp       (temp_view),
    .run        (run_view),
    .settle_busy(settle_busy),
    .stop_busy  (stop_busy)
);

// File: tb/tb_thermal_alert_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_alert_ctrl;
    localparam int SET_C  = 20;
    localparam int STOP_C = 30;

    localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_REP = 8'h08,
                           A_THR0 = 8'h10, A_THR1 = 8'h14, A_THR2 = 8'h18,
                           A_INTC = 8'h20, A_TEMP = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smp_valid = 1'b0;
    logic [8:0]  smp_value = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    thermal_alert_ctrl #(.SETTLE_CYC(SET_C), .STOP_CYC(STOP_C)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
        .smp_value(smp_value), .irq_o(irq_o)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    // monitor: compares one expected item per cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic smp(input logic [8:0] v);
        @(posedge clk); #1;
        smp_valid = 1'b1; smp_value = v;
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic wr_smp(input logic [7:0] a, input logic [31:0] d, input logic [8:0] v);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        smp_valid = 1'b1; smp_value = v;
        @(posedge clk); #1;
        reg_we = 1'b0; smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        exp_reg(A_CTRL, 32'h0, "R1 ctrl");
        exp_reg(A_MODE, 32'h0, "R1 mode");
        exp_reg(A_REP,  32'h0, "R1 repeat");
        exp_reg(A_THR0, 32'h0, "R1 thr0");
        exp_reg(A_INTC, 32'h0, "R1 intc");
        exp_reg(A_TEMP, 32'h0, "R1 temp");
        exp_irq(1'b0, "R1 irq");

        // R2 thresholds
        wr(A_THR0, 32'hAB32_00FF); exp_reg(A_THR0, 32'h0032_0001, "R2 thr0");
        wr(A_THR1, 32'h0064_0001); exp_reg(A_THR1, 32'h0064_0001, "R2 thr1");
        wr(A_THR2, 32'h7F7F_FF01); exp_reg(A_THR2, 32'h007F_0001, "R2 thr2");

        // R11 / R12 mode and repeat fields
        wr(A_MODE, 32'hFFFF_FFF5); exp_reg(A_MODE, 32'h5, "R11 mode");
        wr(A_REP,  32'hFFFF_FFF9); exp_reg(A_REP, 32'h0100_0009, "R12 repeat");

        // R4 interrupt control layout
        wr(A_INTC, 32'hFFFF_FFFF); exp_reg(A_INTC, 32'h111, "R4 intc layout");

        // R8 stopped: sample ignored
        smp(9'd60);
        exp_reg(A_TEMP, 32'h0, "R8 temp while stopped");
        exp_reg(A_INTC, 32'h111, "R8 status while stopped");

        // R9 settle window
        wr(A_CTRL, 32'hFFFF_FFFF);
        exp_reg(A_CTRL, 32'h101, "R9 settle flag");
        smp(9'd60);
        exp_reg(A_TEMP, 32'h0, "R9 sample in settle");
        idle(SET_C + 2);
        exp_reg(A_CTRL, 32'h001, "R9 settle done");

        // R3 / R6 / R7 alert
        smp(9'd60);
        exp_reg(A_TEMP, 32'h03C, "R7 temp 60");
        exp_reg(A_INTC, 32'h113, "R3 ch0 alert");
        exp_irq(1'b1, "R6 irq on");
        smp(9'h1FB);
        exp_reg(A_TEMP, 32'h1FB, "R7 temp -5");
        exp_reg(A_INTC, 32'h113, "R4 sticky");

        // R4 clear
        wr(A_INTC, 32'h115);
        exp_reg(A_INTC, 32'h111, "R4 clear");
        exp_irq(1'b0, "R6 irq off");

        // R5 set beats clear
        wr_smp(A_INTC, 32'h115, 9'd55);
        exp_reg(A_INTC, 32'h113, "R5 set wins");

        // R6 masking
        wr(A_INTC, 32'h110);
        exp_reg(A_INTC, 32'h112, "R6 masked status");
        exp_irq(1'b0, "R6 masked irq");
        wr(A_INTC, 32'h777);
        exp_reg(A_INTC, 32'h111, "R4 clear all");

        // R3 boundaries
        smp(9'd99);
        exp_reg(A_INTC, 32'h113, "R3 99 vs 50/100");
        wr(A_INTC, 32'h777);
        smp(9'd100);
        exp_reg(A_INTC, 32'h133, "R3 equal threshold");
        exp_irq(1'b1, "R6 two channels");
        wr(A_INTC, 32'h777);

        // R11 non-temperature mode
        wr(A_MODE, 32'h3);
        smp(9'd120);
        exp_reg(A_TEMP, 32'h078, "R11 captured");
        exp_reg(A_INTC, 32'h111, "R11 no compare");
        wr(A_MODE, 32'h5);

        // R3 disabled channel
        wr(A_THR0, 32'h0032_0000);
        smp(9'd60);
        exp_reg(A_INTC, 32'h111, "R3 channel disabled");

        // R3 negative vs zero threshold
        wr(A_THR0, 32'h0000_0001);
        smp(9'h1FF);
        exp_reg(A_INTC, 32'h111, "R3 -1 vs 0");
        smp(9'h000);
        exp_reg(A_INTC, 32'h113, "R3 0 vs 0");
        wr(A_INTC, 32'h777);

        // R10 stop window
        wr(A_CTRL, 32'h0);
        exp_reg(A_CTRL, 32'h200, "R10 stop flag");
        wr(A_CTRL, 32'h1);
        exp_reg(A_CTRL, 32'h200, "R10 restart refused");
        smp(9'd7);
        exp_reg(A_TEMP, 32'h0, "R8 stopped sample");
        idle(STOP_C + 2);
        exp_reg(A_CTRL, 32'h0, "R10 stop done");

        // R12 single-shot
        wr(A_REP, 32'h3);
        exp_reg(A_REP, 32'h3, "R12 endless off");
        wr(A_CTRL, 32'h1);
        idle(SET_C + 2);
        smp(9'd10);
        exp_reg(A_TEMP, 32'h00A, "R12 first sample");
        smp(9'd20);
        exp_reg(A_TEMP, 32'h00A, "R12 second ignored");
        wr(A_CTRL, 32'h0);
        idle(STOP_C + 2);
        wr(A_CTRL, 32'h1);
        idle(SET_C + 2);
        smp(9'd20);
        exp_reg(A_TEMP, 32'h014, "R12 rearmed");

        idle(2);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule